// File: doc/BRIEF.md
# Condition Code Flag Register

This block holds the eight status and mask flags of a small accumulator CPU and updates them once per clock. When an ALU operation finishes, the decode logic presents an operation-class code together with the result, the carry out of bit 7, the carry out of bit 3 and the signed-overflow bit. The block then updates only the flags that this class of operation is allowed to touch.

Two other paths act on the same register. The first is a full-register write, used by the transfer-to-flags and return-from-interrupt sequences. It loads every bit, but it can never set the non-maskable-interrupt mask. The second is a set of hardware events: reset, acknowledge of the non-maskable interrupt, and entry to a maskable interrupt. These events set the mask bits and win over a write in the same cycle. A separate output tells the low-power controller whether a stop request may go ahead.

All pins are plain per-cycle controls. The block has no stream interface and no back-pressure, and each input is acted on in the cycle it is presented.

Top module: `ccr_flag_unit`

## Requirements
- R1: The flag vector uses the bit layout stop-disable S=7, X-mask=6, half-carry H=5, I-mask=4, N=3, Z=2, V=1, C=0. While `rst_n` is low the vector is 0xD0, and the first edge after reset leaves it at 0xD0 when no other input is active.
- R2: Class codes are: 0 none, 1 add-with-half-carry, 2 arithmetic, 3 logic, 4 shift/rotate, 5 increment-style. For classes 1 to 5, N takes bit 7 of the result and Z is set exactly when the result is zero.
- R3: For classes 1, 2 and 4, C takes `carry7`. For every other class, C keeps its value.
- R4: For classes 1, 2, 4 and 5, V takes `ovf`. Class 3 clears V, and the remaining classes keep it.
- R5: H takes `carry3` only for class 1. Every other class leaves H unchanged.
- R6: With `op_valid` low, or with class 0, 6 or 7, no flag changes.
- R7: When `wr_en` is high, S, H, I, N, Z, V and C load from `wr_data` on the next edge, and any ALU update in the same cycle is discarded.
- R8: On a write, X becomes the old X AND `wr_data[6]`. A write can clear X but never set it.
- R9: `nmi_ack` sets both X and I, and `irq_entry` sets I only. Both take priority over a write in the same cycle.
- R10: `stop_ok` is high exactly when S is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An ALU result is present this cycle |
| op_cls | input | 3 | Operation class code (see R2) |
| res | input | DATA_W | ALU result |
| carry7 | input | 1 | Carry or borrow out of the top bit |
| carry3 | input | 1 | Carry from bit 3 into bit 4 |
| ovf | input | 1 | Signed overflow of the operation |
| wr_en | input | 1 | Full-register write strobe |
| wr_data | input | 8 | Full-register write value |
| nmi_ack | input | 1 | Non-maskable interrupt acknowledge |
| irq_entry | input | 1 | Maskable interrupt entry |
| ccr | output | 8 | Flag vector |
| stop_ok | output | 1 | Stop request permitted |

## Verification
The assertions are evaluated on every cycle. They check that X rises only after a non-maskable acknowledge, and that H is held by any class other than 1. They also check that logic operations clear V, that Z and N follow the result, that hardware events set their masks, and that the register stays still when nothing is active. The exact carry, overflow and half-carry values over every result, every class and every carry combination can only be shown by the bench's sweeps. The same holds for the masked load of X, the precedence of a write over an ALU update, the precedence of hardware events over a write, and the stop permission.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W = 8;
  localparam int B_C = 0;
  localparam int B_V = 1;
  localparam int B_Z = 2;
  localparam int B_N = 3;
  localparam int B_I = 4;
  localparam int B_H = 5;
  localparam int B_X = 6;
  localparam int B_S = 7;
  localparam logic [CCR_W-1:0] RESET_VAL = 8'hD0;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_ADDH  = 3'd1,
    CLS_ARITH = 3'd2,
    CLS_LOGIC = 3'd3,
    CLS_SHIFT = 3'd4,
    CLS_INCR  = 3'd5
  } op_cls_e;

  typedef struct packed {
    logic upd_nz;
    logic upd_v;
    logic clr_v;
    logic upd_c;
    logic upd_h;
  } upd_t;
endpackage

// File: rtl/ccr_class_dec.sv
module ccr_class_dec
  import ccr_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] cls,
  output upd_t       upd
);
  always_comb begin
    upd = '0;
    if (valid) begin
      case (cls)
        CLS_ADDH:  begin upd.upd_nz = 1'b1; upd.upd_v = 1'b1; upd.upd_c = 1'b1; upd.upd_h = 1'b1; end
        CLS_ARITH: begin upd.upd_nz = 1'b1; upd.upd_v = 1'b1; upd.upd_c = 1'b1; end
        CLS_LOGIC: begin upd.upd_nz = 1'b1; upd.clr_v = 1'b1; end
        CLS_SHIFT: begin upd.upd_nz = 1'b1; upd.upd_v = 1'b1; upd.upd_c = 1'b1; end
        CLS_INCR:  begin upd.upd_nz = 1'b1; upd.upd_v = 1'b1; end
        default:   upd = '0;
      endcase
    end
  end
endmodule

// File: rtl/ccr_result_flags.sv
module ccr_result_flags
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  upd_t              upd,
  input  logic [DATA_W-1:0] res,
  input  logic              carry7,
  input  logic              carry3,
  input  logic              ovf,
  input  logic [CCR_W-1:0]  cur,
  output logic [CCR_W-1:0]  nxt
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    nxt = cur;
    if (upd.upd_nz) begin
      nxt[B_N] = res[MSB];
      nxt[B_Z] = (res == '0);
    end
    if (upd.upd_v) nxt[B_V] = ovf;
    if (upd.clr_v) nxt[B_V] = 1'b0;
    if (upd.upd_c) nxt[B_C] = carry7;
    if (upd.upd_h) nxt[B_H] = carry3;
  end
endmodule

// File: rtl/ccr_mask_ctl.sv
module ccr_mask_ctl
  import ccr_pkg::*;
(
  input  logic [CCR_W-1:0] cur,
  input  logic [CCR_W-1:0] alu_nxt,
  input  logic             wr_en,
  input  logic [CCR_W-1:0] wr_data,
  input  logic             nmi_ack,
  input  logic             irq_entry,
  output logic [CCR_W-1:0] nxt
);
  logic [CCR_W-1:0] wr_val;

  always_comb begin
    wr_val       = wr_data;
    wr_val[B_X]  = cur[B_X] & wr_data[B_X];
    nxt          = wr_en ? wr_val : alu_nxt;
    if (nmi_ack) begin
      nxt[B_X] = 1'b1;
      nxt[B_I] = 1'b1;
    end
    if (irq_entry) nxt[B_I] = 1'b1;
  end
endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_cls,
  input  logic [DATA_W-1:0] res,
  input  logic              carry7,
  input  logic              carry3,
  input  logic              ovf,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              nmi_ack,
  input  logic              irq_entry,
  output logic [7:0]        ccr,
  output logic              stop_ok
);
  upd_t             upd;
  logic [CCR_W-1:0] ccr_q;
  logic [CCR_W-1:0] alu_nxt;
  logic [CCR_W-1:0] ccr_d;

  ccr_class_dec i_dec (
    .valid (op_valid),
    .cls   (op_cls),
    .upd   (upd)
  );

  ccr_result_flags #(.DATA_W(DATA_W)) i_res (
    .upd    (upd),
    .res    (res),
    .carry7 (carry7),
    .carry3 (carry3),
    .ovf    (ovf),
    .cur    (ccr_q),
    .nxt    (alu_nxt)
  );

  ccr_mask_ctl i_mask (
    .cur       (ccr_q),
    .alu_nxt   (alu_nxt),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .nmi_ack   (nmi_ack),
    .irq_entry (irq_entry),
    .nxt       (ccr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ccr_q <= RESET_VAL;
    else        ccr_q <= ccr_d;
  end

  assign ccr     = ccr_q;
  assign stop_ok = ~ccr_q[B_S];
endmodule

// File: rtl/ccr_flag_checker.sv
module ccr_flag_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_cls,
  input logic [DATA_W-1:0] res,
  input logic              wr_en,
  input logic              nmi_ack,
  input logic              irq_entry,
  input logic [7:0]        ccr
);
  logic nz_cls;
  assign nz_cls = op_valid && (op_cls >= 3'd1) && (op_cls <= 3'd5);

  p_x_only_by_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ccr[6]) |-> $past(nmi_ack));

  p_h_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(op_valid && op_cls == 3'd1)) |=> $stable(ccr[5]));

  p_logic_clears_v_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && op_valid && op_cls == 3'd3) |=> !ccr[1]);

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && nz_cls) |=> (ccr[2] == ($past(res) == '0)));

  p_neg_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && nz_cls) |=> (ccr[3] == $past(res[DATA_W-1])));

  p_nmi_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |=> (ccr[6] && ccr[4]));

  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> ccr[4]);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !wr_en && !nmi_ack && !irq_entry) |=> $stable(ccr));
endmodule

bind ccr_flag_unit ccr_flag_checker #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_cls    (op_cls),
  .res       (res),
  .wr_en     (wr_en),
  .nmi_ack   (nmi_ack),
  .irq_entry (irq_entry),
  .ccr       (ccr)
);

// File: tb/test_ccr_flag_unit.sv
module test_ccr_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid, carry7, carry3, ovf, wr_en, nmi_ack, irq_entry;
  logic [2:0] op_cls;
  logic [7:0] res, wr_data, ccr;
  logic       stop_ok;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [7:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_flag_unit #(.DATA_W(8)) i_ccr_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cls(op_cls), .res(res),
    .carry7(carry7), .carry3(carry3), .ovf(ovf), .wr_en(wr_en), .wr_data(wr_data),
    .nmi_ack(nmi_ack), .irq_entry(irq_entry), .ccr(ccr), .stop_ok(stop_ok)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_op(logic [7:0] o, int cls, logic [7:0] r,
                                          logic c7, logic c3, logic v);
    logic [7:0] n;
    n = o;
    if (cls >= 1 && cls <= 5) begin n[3] = r[7]; n[2] = (r == 8'd0); end
    if (cls == 1 || cls == 2 || cls == 4) n[0] = c7;
    if (cls == 1 || cls == 2 || cls == 4 || cls == 5) n[1] = v;
    if (cls == 3) n[1] = 1'b0;
    if (cls == 1) n[5] = c3;
    return n;
  endfunction

  task automatic idle_inputs();
    op_valid = 0; op_cls = 0; res = 0; carry7 = 0; carry3 = 0; ovf = 0;
    wr_en = 0; wr_data = 0; nmi_ack = 0; irq_entry = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(negedge clk);
    chk("R1 reset value", ccr, 8'hD0);
    chk("R10 stop_ok in reset", {7'd0, stop_ok}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", ccr, 8'hD0);
    model = 8'hD0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    do_reset();

    // ALU class sweep: every class, every result, every carry/overflow mix
    for (int cls = 0; cls < 8; cls++) begin
      for (int r = 0; r < 256; r++) begin
        for (int k = 0; k < 8; k++) begin
          logic [7:0] exp;
          op_valid = 1; op_cls = 3'(cls); res = 8'(r);
          carry7 = k[0]; carry3 = k[1]; ovf = k[2];
          exp = model_op(model, cls, 8'(r), k[0], k[1], k[2]);
          @(negedge clk);
          chk("R2 N/Z", ccr & 8'h0C, exp & 8'h0C);
          chk("R3 C",   ccr & 8'h01, exp & 8'h01);
          chk("R4 V",   ccr & 8'h02, exp & 8'h02);
          chk("R5 H",   ccr & 8'h20, exp & 8'h20);
          if (cls == 0 || cls > 5) chk("R6 no-op class", ccr, model);
          model = exp;
        end
      end
    end

    // op_valid low: nothing changes whatever the other inputs say
    for (int k = 0; k < 16; k++) begin
      op_valid = 0; op_cls = 3'(k % 6); res = 8'(k * 17);
      carry7 = ~model[0]; carry3 = ~model[5]; ovf = ~model[1];
      @(negedge clk);
      chk("R6 op_valid low", ccr, model);
    end

    // Full writes, with X preset to 1 (via NMI) and to 0 (via write)
    for (int w = 0; w < 256; w++) begin
      for (int pre = 0; pre < 2; pre++) begin
        logic [7:0] exp;
        idle_inputs();
        if (pre == 1) begin nmi_ack = 1; model = model | 8'h50; end
        else begin wr_en = 1; wr_data = 8'h00; model = {1'b0, 1'b0, 6'd0}; end
        @(negedge clk);
        idle_inputs();
        wr_en = 1; wr_data = 8'(w);
        op_valid = 1; op_cls = 3'd2; res = 8'(w) ^ 8'h5A; carry7 = 1; carry3 = 1; ovf = 1;
        exp = {wr_data[7], model[6] & wr_data[6], wr_data[5:0]};
        @(negedge clk);
        chk("R7 write load", ccr & 8'hBF, exp & 8'hBF);
        chk("R8 X masked", ccr & 8'h40, exp & 8'h40);
        chk("R10 stop_ok", {7'd0, stop_ok}, {7'd0, ~exp[7]});
        model = exp;
      end
    end

    // Hardware events against a write in the same cycle
    for (int w = 0; w < 256; w++) begin
      for (int e = 0; e < 4; e++) begin
        logic [7:0] exp;
        idle_inputs();
        wr_en = 1; wr_data = 8'(w); nmi_ack = e[0]; irq_entry = e[1];
        exp = {wr_data[7], model[6] & wr_data[6], wr_data[5:0]};
        if (e[0]) exp = exp | 8'h50;
        if (e[1]) exp = exp | 8'h10;
        @(negedge clk);
        chk("R9 hw over write", ccr & 8'h50, exp & 8'h50);
        chk("R7 other bits", ccr & 8'hAF, exp & 8'hAF);
        model = exp;
      end
    end

    // IRQ entry alone sets I only
    idle_inputs();
    wr_en = 1; wr_data = 8'h00;
    @(negedge clk);
    idle_inputs();
    irq_entry = 1;
    @(negedge clk);
    chk("R9 irq sets I only", ccr, 8'h10);
    idle_inputs();

    do_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule